// File: doc/BRIEF.md
# PCI Interrupt Line Steering Router

This block takes four shared, level-sensitive PCI interrupt request lines and steers each of them onto one of a bank of legacy interrupt-controller inputs. Each line has its own one-byte route value, held in a small byte-wide configuration port. A route value below the number of controller inputs selects that input. Any larger value turns the line off. Each controller input is driven high while at least one request line steered to it is high, so several lines can share one input.

Internally the block keeps a level map with one bit per (target, line) pair, at index target × 4 + line. Every clock cycle the map is rebuilt from the live request levels and the route values. A route write is applied to the rebuild in the same cycle, so the outputs follow a route change one clock after the write edge. The block reports each line's current routing as an enable bit plus a target number.

A separate combinational helper computes which shared line a device's interrupt pin lands on. The result depends on the device's slot number, which is taken from its device/function byte.

Top module: `pirq_router`

## Requirements
- R1: After reset every route register reads 0x80, every `irqOut` bit is 0 and every `routeEn` bit is 0.
- R2: A read at address BASE_ADDR+k (k = 0..3, default base 0x60) returns route byte k on `cfgRdData` combinationally, and has no side effects. Any other address reads 0x00. A write to any other address changes no route register.
- R3: Line k is enabled when its route byte is less than NUM_TARGETS (default 16). In that case `routeEn[k]` is 1 and `routeTarget[4k+3:4k]` holds the byte's value. Values from NUM_TARGETS to 255 give `routeEn[k]` = 0 and a target field of 0.
- R4: `irqOut[t]` is 1 exactly when some enabled line routed to t has its `reqLevel` bit high. The output follows a level change one clock later.
- R5: A route write takes effect on `irqOut`, `routeEn` and `routeTarget` one clock after the write edge. A line that is moved stops driving its previous target at that same point.
- R6: A level change on a disabled line changes no output.
- R7: When several lines share one target, the output stays high until the last of those lines goes low.
- R8: `swzLine` = (`devPin` + `devFn[7:3]` − 1) mod 4, computed combinationally. `devPin` encodes INTA..INTD as 0..3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgAddr | input | 8 | Configuration byte address |
| cfgWrData | input | 8 | Configuration write data |
| cfgWe | input | 1 | Configuration write strobe |
| cfgRdData | output | 8 | Configuration read data (combinational) |
| reqLevel | input | 4 | Live levels of the shared request lines |
| irqOut | output | NUM_TARGETS | Controller input levels |
| routeEn | output | 4 | Per-line routing enable |
| routeTarget | output | 4*TGT_W | Per-line target number, line k at bits [TGT_W*k +: TGT_W] |
| devFn | input | 8 | Device/function byte used by the pin swizzle |
| devPin | input | 2 | Device interrupt pin (0=INTA .. 3=INTD) |
| swzLine | output | 2 | Shared line selected by the swizzle |

## Verification
The bench builds the block with its default values: four lines, sixteen targets and a base address of 0x60. With an 8-bit route byte, this makes it practical to write all 256 route values on every line, and to check the enable flag, the target and the read-back for each one. All 1024 combinations of device/function byte and pin are swept through the swizzle. Several hundred random mixes of route bytes (about half of them out of range) and request levels are compared against an OR-reduction model kept in the bench. Directed cases cover shared targets, moving a line that is asserted, and toggling a line while it is disabled.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
  localparam int NUM_LINES = 4;
  localparam int LINE_W = 2;
  localparam logic [7:0] ROUTE_RESET = 8'h80;

  typedef struct packed {
    logic              wrEn;
    logic [LINE_W-1:0] wrLine;
    logic [7:0]        wrData;
    logic              rdHit;
    logic [LINE_W-1:0] rdLine;
  } cfgStrobe_t;
endpackage

// File: rtl/pirq_cfg_ctrl.sv
module pirq_cfg_ctrl
  import pirq_pkg::*;
#(
  parameter logic [7:0] BASE_ADDR = 8'h60
) (
  input  logic [7:0] cfgAddr,
  input  logic [7:0] cfgWrData,
  input  logic       cfgWe,
  output cfgStrobe_t strobe
);
  logic [7:0] offs;
  logic       hit;

  // Wrap-around subtraction puts addresses below the base out of range too.
  assign offs = cfgAddr - BASE_ADDR;
  assign hit  = (offs < 8'(NUM_LINES));

  always_comb begin
    strobe.wrEn   = cfgWe && hit;
    strobe.wrLine = offs[LINE_W-1:0];
    strobe.wrData = cfgWrData;
    strobe.rdHit  = hit;
    strobe.rdLine = offs[LINE_W-1:0];
  end
endmodule

// File: rtl/pirq_route_dp.sv
module pirq_route_dp
  import pirq_pkg::*;
#(
  parameter int NUM_TARGETS = 16,
  localparam int TGT_W = $clog2(NUM_TARGETS),
  localparam int MAP_W = NUM_TARGETS * NUM_LINES
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  cfgStrobe_t                 strobe,
  input  logic [NUM_LINES-1:0]       reqLevel,
  output logic [NUM_TARGETS-1:0]     irqOut,
  output logic [NUM_LINES-1:0]       routeEn,
  output logic [NUM_LINES*TGT_W-1:0] routeTarget,
  output logic [7:0]                 rdData
);
  logic [7:0]       routeQ    [NUM_LINES];
  logic [7:0]       routeNext [NUM_LINES];
  logic [MAP_W-1:0] levelMapQ;
  logic [MAP_W-1:0] levelMapNext;

  // Route values after this cycle's write, so the map rebuild sees them at once.
  always_comb begin
    for (int i = 0; i < NUM_LINES; i++) begin
      routeNext[i] = routeQ[i];
      if (strobe.wrEn && (int'(strobe.wrLine) == i)) routeNext[i] = strobe.wrData;
    end
  end

  // Level map rebuilt every cycle: bit (target*NUM_LINES + line).
  always_comb begin
    levelMapNext = '0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (int'(routeNext[i]) < NUM_TARGETS)
        levelMapNext[int'(routeNext[i][TGT_W-1:0]) * NUM_LINES + i] = reqLevel[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_LINES; i++) routeQ[i] <= ROUTE_RESET;
      levelMapQ <= '0;
    end else begin
      for (int i = 0; i < NUM_LINES; i++) routeQ[i] <= routeNext[i];
      levelMapQ <= levelMapNext;
    end
  end

  for (genvar t = 0; t < NUM_TARGETS; t++) begin : g_out
    assign irqOut[t] = |levelMapQ[t*NUM_LINES +: NUM_LINES];
  end

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    logic lineOn;
    assign lineOn = (int'(routeQ[i]) < NUM_TARGETS);
    assign routeEn[i] = lineOn;
    assign routeTarget[i*TGT_W +: TGT_W] = lineOn ? routeQ[i][TGT_W-1:0] : '0;
  end

  assign rdData = strobe.rdHit ? routeQ[strobe.rdLine] : 8'h00;
endmodule

// File: rtl/pirq_swizzle.sv
module pirq_swizzle
  import pirq_pkg::*;
(
  input  logic [7:0]        devFn,
  input  logic [1:0]        devPin,
  output logic [LINE_W-1:0] swzLine
);
  logic [4:0] sum;
  assign sum     = devFn[7:3] + 5'(devPin) - 5'd1;
  assign swzLine = sum[LINE_W-1:0];
endmodule

// File: rtl/pirq_router.sv
module pirq_router
  import pirq_pkg::*;
#(
  parameter int NUM_TARGETS = 16,
  parameter logic [7:0] BASE_ADDR = 8'h60,
  localparam int TGT_W = $clog2(NUM_TARGETS)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [7:0]                 cfgAddr,
  input  logic [7:0]                 cfgWrData,
  input  logic                       cfgWe,
  output logic [7:0]                 cfgRdData,
  input  logic [NUM_LINES-1:0]       reqLevel,
  output logic [NUM_TARGETS-1:0]     irqOut,
  output logic [NUM_LINES-1:0]       routeEn,
  output logic [NUM_LINES*TGT_W-1:0] routeTarget,
  input  logic [7:0]                 devFn,
  input  logic [1:0]                 devPin,
  output logic [1:0]                 swzLine
);
  cfgStrobe_t strobe;

  pirq_cfg_ctrl #(.BASE_ADDR(BASE_ADDR)) u_ctrl (
    .cfgAddr  (cfgAddr),
    .cfgWrData(cfgWrData),
    .cfgWe    (cfgWe),
    .strobe   (strobe)
  );

  pirq_route_dp #(.NUM_TARGETS(NUM_TARGETS)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .reqLevel   (reqLevel),
    .irqOut     (irqOut),
    .routeEn    (routeEn),
    .routeTarget(routeTarget),
    .rdData     (cfgRdData)
  );

  pirq_swizzle u_swz (
    .devFn  (devFn),
    .devPin (devPin),
    .swzLine(swzLine)
  );
endmodule

// File: rtl/pirq_router_chk.sv
module pirq_router_chk
  import pirq_pkg::*;
#(
  parameter int NUM_TARGETS = 16,
  parameter logic [7:0] BASE_ADDR = 8'h60,
  localparam int TGT_W = $clog2(NUM_TARGETS)
) (
  input logic                       clk,
  input logic                       rstN,
  input logic [7:0]                 cfgAddr,
  input logic [7:0]                 cfgWrData,
  input logic                       cfgWe,
  input logic [7:0]                 cfgRdData,
  input logic [NUM_LINES-1:0]       reqLevel,
  input logic [NUM_TARGETS-1:0]     irqOut,
  input logic [NUM_LINES-1:0]       routeEn,
  input logic [NUM_LINES*TGT_W-1:0] routeTarget
);
  // R2: addresses outside the route window read zero
  p_rd_outside_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    ((int'(cfgAddr) < int'(BASE_ADDR)) || (int'(cfgAddr) >= int'(BASE_ADDR) + NUM_LINES))
      |-> (cfgRdData == 8'h00));

  // R6: with every line disabled and no write, nothing can be driven
  p_all_off_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    ((routeEn == '0) && !cfgWe) |=> (irqOut == '0));

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_lchk
    // R3: a disabled line reports target zero
    p_off_target_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
      !routeEn[i] |-> (routeTarget[i*TGT_W +: TGT_W] == '0));

    // R5: an in-range route write is visible one clock later
    p_write_lands_r5: assert property (@(posedge clk) disable iff (!rstN)
      (cfgWe && (int'(cfgAddr) == int'(BASE_ADDR) + i) && (int'(cfgWrData) < NUM_TARGETS))
        |=> (routeEn[i] && (routeTarget[i*TGT_W +: TGT_W] == $past(cfgWrData[TGT_W-1:0]))));

    // R4: a high, enabled line drives its target on the next clock
    p_level_drives_r4: assert property (@(posedge clk) disable iff (!rstN)
      (!cfgWe && routeEn[i] && reqLevel[i])
        |=> irqOut[$past(routeTarget[i*TGT_W +: TGT_W])]);
  end
endmodule

bind pirq_router pirq_router_chk #(.NUM_TARGETS(NUM_TARGETS), .BASE_ADDR(BASE_ADDR)) u_chk (
  .clk(clk), .rstN(rstN), .cfgAddr(cfgAddr), .cfgWrData(cfgWrData), .cfgWe(cfgWe),
  .cfgRdData(cfgRdData), .reqLevel(reqLevel), .irqOut(irqOut), .routeEn(routeEn),
  .routeTarget(routeTarget)
);

// File: tb/sim_pirq_router.sv
`timescale 1ns/1ps
module sim_pirq_router;
  localparam int NT = 16;
  localparam int NL = 4;
  localparam logic [7:0] BASE = 8'h60;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  cfgAddr = 8'h00;
  logic [7:0]  cfgWrData = 8'h00;
  logic        cfgWe = 1'b0;
  logic [7:0]  cfgRdData;
  logic [3:0]  reqLevel = 4'h0;
  logic [15:0] irqOut;
  logic [3:0]  routeEn;
  logic [15:0] routeTarget;
  logic [7:0]  devFn = 8'h00;
  logic [1:0]  devPin = 2'd0;
  logic [1:0]  swzLine;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [7:0] expRoute [NL];

  always #2.5 clk = ~clk;

  pirq_router u0 (
    .clk(clk), .rstN(rstN), .cfgAddr(cfgAddr), .cfgWrData(cfgWrData), .cfgWe(cfgWe),
    .cfgRdData(cfgRdData), .reqLevel(reqLevel), .irqOut(irqOut), .routeEn(routeEn),
    .routeTarget(routeTarget), .devFn(devFn), .devPin(devPin), .swzLine(swzLine)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] modelOut();
    logic [15:0] o = '0;
    for (int i = 0; i < NL; i++)
      if (int'(expRoute[i]) < NT && reqLevel[i]) o[expRoute[i][3:0]] = 1'b1;
    return o;
  endfunction

  function automatic logic [3:0] modelEn();
    logic [3:0] e;
    for (int i = 0; i < NL; i++) e[i] = (int'(expRoute[i]) < NT);
    return e;
  endfunction

  function automatic logic [15:0] modelTgt();
    logic [15:0] t = '0;
    for (int i = 0; i < NL; i++)
      if (int'(expRoute[i]) < NT) t[i*4 +: 4] = expRoute[i][3:0];
    return t;
  endfunction

  task automatic wr(input logic [7:0] addr, input logic [7:0] val);
    @(negedge clk);
    cfgAddr = addr; cfgWrData = val; cfgWe = 1'b1;
    @(negedge clk);
    cfgWe = 1'b0;
    if (addr >= BASE && addr < BASE + 8'(NL)) expRoute[addr - BASE] = val;
  endtask

  task automatic rd(input logic [7:0] addr, output logic [7:0] val);
    cfgAddr = addr;
    #1;
    val = cfgRdData;
  endtask

  task automatic setLvl(input logic [3:0] v);
    @(negedge clk);
    reqLevel = v;
    @(negedge clk);
  endtask

  task automatic chkAll(input string req);
    chk(req, 32'(irqOut), 32'(modelOut()));
    chk(req, 32'(routeEn), 32'(modelEn()));
    chk(req, 32'(routeTarget), 32'(modelTgt()));
  endtask

  initial begin
    logic [7:0] r;
    logic [15:0] prev;
    for (int i = 0; i < NL; i++) expRoute[i] = 8'h80;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int i = 0; i < NL; i++) begin
      rd(BASE + 8'(i), r);
      chk("R1 reset route byte", 32'(r), 32'h80);
    end
    chk("R1 reset irqOut", 32'(irqOut), 32'h0);
    chk("R1 reset routeEn", 32'(routeEn), 32'h0);

    // R3 and R2: every route value on every line
    setLvl(4'hF);
    for (int i = 0; i < NL; i++) begin
      for (int v = 0; v < 256; v++) begin
        wr(BASE + 8'(i), 8'(v));
        chkAll("R3 sweep");
        rd(BASE + 8'(i), r);
        chk("R2 readback", 32'(r), 32'(v));
      end
      wr(BASE + 8'(i), 8'h80);
    end

    // R2: writes outside the window are ignored, reads there give zero
    wr(BASE, 8'h03);
    wr(BASE - 8'd1, 8'h05);
    wr(BASE + 8'd4, 8'h06);
    wr(8'h00, 8'h07);
    for (int i = 0; i < NL; i++) begin
      rd(BASE + 8'(i), r);
      chk("R2 outside write ignored", 32'(r), 32'(expRoute[i]));
    end
    rd(BASE - 8'd1, r); chk("R2 outside read", 32'(r), 32'h0);
    rd(BASE + 8'd4, r); chk("R2 outside read", 32'(r), 32'h0);
    chkAll("R2 outputs after outside writes");

    // R7: shared target
    setLvl(4'h0);
    wr(BASE, 8'd5); wr(BASE + 8'd1, 8'd5); wr(BASE + 8'd2, 8'hFF); wr(BASE + 8'd3, 8'h10);
    setLvl(4'b0011);
    chk("R7 both high", 32'(irqOut), 32'h0020);
    setLvl(4'b0010);
    chk("R7 one still high", 32'(irqOut), 32'h0020);
    setLvl(4'b0000);
    chk("R7 all low", 32'(irqOut), 32'h0000);

    // R6: toggling disabled lines changes nothing
    setLvl(4'b0001);
    prev = irqOut;
    setLvl(4'b1101);
    chk("R6 disabled lines high", 32'(irqOut), 32'(prev));
    setLvl(4'b0001);
    chk("R6 disabled lines low", 32'(irqOut), 32'(prev));

    // R5: move an asserted line
    wr(BASE, 8'd2);
    chk("R5 moved line new target", 32'(irqOut), 32'h0004);
    wr(BASE, 8'd9);
    chk("R5 old target dropped", 32'(irqOut), 32'h0200);
    wr(BASE, 8'd200);
    chk("R5 disable asserted line", 32'(irqOut), 32'h0000);

    // R4: one-clock latency of a level change
    wr(BASE + 8'd3, 8'd15);
    @(negedge clk); reqLevel = 4'b1000;
    @(posedge clk); #1;
    chk("R4 output after one clock", 32'(irqOut), 32'h8000);

    // R4/R5: random routes and levels
    for (int n = 0; n < 400; n++) begin
      logic [7:0] v = 8'($urandom);
      if ($urandom_range(0, 1) == 0) v = 8'($urandom_range(0, NT - 1));
      wr(BASE + 8'($urandom_range(0, NL - 1)), v);
      chkAll("R5 random route");
      setLvl(4'($urandom));
      chkAll("R4 random levels");
    end

    // R8: swizzle sweep
    for (int f = 0; f < 256; f++) begin
      for (int p = 0; p < 4; p++) begin
        devFn = 8'(f); devPin = 2'(p);
        #1;
        chk("R8 swizzle", 32'(swzLine), 32'((p + (f >> 3) - 1) & 3));
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule